// File: doc/BRIEF.md
# Debounced Interrupt Sense Controller

This block watches a set of asynchronous status inputs, such as supply detectors, ID pin comparators, thermal warnings and push-button pins. Each input is brought into the clock domain through two flip-flops and then settled by a per-source debounce state machine. The machine has its own tick count for a rising change and another for a falling change, and the tick comes from a slow (nominally 32 kHz) enable. The settled level is published as a sense bit. Each settled change that matches the source's trigger mode (rising only, falling only, or both) sets a sticky interrupt flag. A per-source mask decides which flags drive the shared interrupt line.

Software uses a small register port. It reads the sense bits, reads the flags and clears them by writing ones, and reads or writes the masks. Sources with extension enabled, typically push-button pins, take a 2-bit setting that multiplies their falling settle time by 1, 2, 4 or 8. With a 30 ms base this gives 30, 60, 120 or 240 ms.

Each debounce machine has two states. ST_STABLE holds the accepted level. The transition *mismatch* leaves it for ST_SETTLE when the synchronized input differs and the count for that direction is non-zero. With a zero count, the *instant* transition updates the level in place. From ST_SETTLE, *abort* returns to ST_STABLE when the input goes back to the held level. *Accept* returns to ST_STABLE and updates the level on the tick that completes the count. Ticks are counted only while `tick_en` is high.

Top module: `irq_sense_ctrl`

## Requirements
- R1: A change on `pin[i]` reaches the sense bit through a two-flop synchronizer. For a source with a count of L ticks (tick every cycle), the new level is visible after the (3+L)-th rising clock edge following the change, and not after the (2+L)-th.
- R2: A level that holds for fewer ticks than the count, and then returns to the accepted level, changes neither the sense bit nor the flag. A later change starts a fresh count.
- R3: Each source has an independent rising count (RISE_TICKS) and falling count (FALL_TICKS).
- R4: For a source whose EXT_EN bit is 1, the falling count is FALL_TICKS shifted left by `fall_ext[2i+1:2i]` (codes 0..3 give x1, x2, x4, x8). For other sources, `fall_ext` has no effect.
- R5: MODES[2i+1:2i] selects the trigger: 0 = rising only, 1 = falling only, 2 = both. Only matching accepted changes set flag i.
- R6: A flag stays set until a write of 1 to its bit at address 1. When a clear and a new matching change meet in the same cycle, the flag stays set.
- R7: `irq` is high exactly while some flag is set with its mask bit at 0.
- R8: Register map: address 0 reads the sense bits and ignores writes. Address 1 reads the flags and is write-one-to-clear. Address 2 reads and writes the masks. Address 3 reads zero.
- R9: After reset, the sense bits and flags are 0, the masks are all 1 and `irq` is 0.
- R10: While `tick_en` is low, a pending non-zero count does not advance and the sense bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Debounce tick enable (nominally 32 kHz) |
| pin | input | N | Asynchronous status inputs |
| fall_ext | input | 2*N | Per-source falling settle multiplier code |
| addr | input | 2 | Register address |
| wr | input | 1 | Write strobe |
| wdata | input | N | Write data |
| rdata | output | N | Read data for `addr` |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume that `pin` meets the synchronizer's setup, so that the sense bit always takes a value the pin held two edges earlier. They also assume that `fall_ext` changes only while its source is settled. The stimulus drives every input at the falling clock edge and changes `fall_ext` only after a long hold. It keeps random glitches at least two ticks shorter than the count for that direction, so the expected sense and flag values never depend on a race at the count boundary.

// File: rtl/isc_pkg.sv
package isc_pkg;
    typedef enum logic {ST_STABLE, ST_SETTLE} db_state_e;

    localparam logic [1:0] MODE_RISE = 2'd0;
    localparam logic [1:0] MODE_FALL = 2'd1;
    localparam logic [1:0] MODE_DUAL = 2'd2;

    localparam logic [1:0] ADDR_SENSE = 2'd0;
    localparam logic [1:0] ADDR_FLAG  = 2'd1;
    localparam logic [1:0] ADDR_MASK  = 2'd2;
endpackage

// File: rtl/isc_sync.sv
module isc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/isc_debounce.sv
module isc_debounce
    import isc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          lvl,
    input  logic [CW-1:0] rise_lim,
    input  logic [CW-1:0] fall_lim,
    output logic          sense,
    output logic          rise_p,
    output logic          fall_p
);
    db_state_e     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          sense_n, rise_n, fall_n;
    logic [CW-1:0] lim;
    logic [CW:0]   inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_STABLE;
            cnt    <= '0;
            sense  <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            sense  <= sense_n;
            rise_p <= rise_n;
            fall_p <= fall_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sense_n = sense;
        rise_n  = 1'b0;
        fall_n  = 1'b0;
        lim     = lvl ? rise_lim : fall_lim;
        inc     = {1'b0, cnt} + (CW+1)'(1);
        unique case (state)
            ST_STABLE: begin
                if (lvl != sense) begin
                    if (lim == '0) begin
                        sense_n = lvl;
                        rise_n  = lvl;
                        fall_n  = !lvl;
                    end else begin
                        state_n = ST_SETTLE;
                        cnt_n   = '0;
                    end
                end
            end
            ST_SETTLE: begin
                if (lvl == sense) begin
                    state_n = ST_STABLE;
                end else if (tick_en) begin
                    if (inc >= {1'b0, lim}) begin
                        state_n = ST_STABLE;
                        sense_n = lvl;
                        rise_n  = lvl;
                        fall_n  = !lvl;
                    end else begin
                        cnt_n = inc[CW-1:0];
                    end
                end
            end
            default: state_n = ST_STABLE;
        endcase
    end
endmodule

// File: rtl/isc_regs.sv
module isc_regs
    import isc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] sense,
    input  logic [1:0]   addr,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    output logic [N-1:0] flag,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr;

    assign clr = (wr && addr == ADDR_FLAG) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= '0;
            mask <= '1;
        end else begin
            flag <= (flag & ~clr) | ev;
            if (wr && addr == ADDR_MASK) mask <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_SENSE: rdata = sense;
            ADDR_FLAG:  rdata = flag;
            ADDR_MASK:  rdata = mask;
            default:    rdata = '0;
        endcase
    end

    assign irq = |(flag & ~mask);
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import isc_pkg::*;
#(
    parameter int             N          = 4,
    parameter int             CW         = 16,
    parameter logic [N*CW-1:0] RISE_TICKS = {16'd3, 16'd983, 16'd721, 16'd0},
    parameter logic [N*CW-1:0] FALL_TICKS = {16'd3, 16'd983, 16'd328, 16'd0},
    parameter logic [2*N-1:0]  MODES      = {MODE_DUAL, MODE_FALL, MODE_DUAL, MODE_RISE},
    parameter logic [N-1:0]    EXT_EN     = 4'b0100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic [N-1:0]   pin,
    input  logic [2*N-1:0] fall_ext,
    input  logic [1:0]     addr,
    input  logic           wr,
    input  logic [N-1:0]   wdata,
    output logic [N-1:0]   rdata,
    output logic           irq
);
    logic [N-1:0] lvl, sense, rise_p, fall_p, ev, flag, mask;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam logic [CW-1:0] RL   = RISE_TICKS[i*CW +: CW];
        localparam logic [CW-1:0] FL   = FALL_TICKS[i*CW +: CW];
        localparam logic [1:0]    MODE = MODES[2*i +: 2];
        logic [CW-1:0] fall_lim;

        assign fall_lim = EXT_EN[i] ? (FL << fall_ext[2*i +: 2]) : FL;

        isc_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin[i]),
            .q    (lvl[i])
        );

        isc_debounce #(.CW(CW)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .lvl     (lvl[i]),
            .rise_lim(RL),
            .fall_lim(fall_lim),
            .sense   (sense[i]),
            .rise_p  (rise_p[i]),
            .fall_p  (fall_p[i])
        );

        if (MODE == MODE_RISE) begin : g_rise
            assign ev[i] = rise_p[i];
        end else if (MODE == MODE_FALL) begin : g_fall
            assign ev[i] = fall_p[i];
        end else begin : g_dual
            assign ev[i] = rise_p[i] | fall_p[i];
        end
    end

    isc_regs #(.N(N)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev),
        .sense(sense),
        .addr (addr),
        .wr   (wr),
        .wdata(wdata),
        .rdata(rdata),
        .flag (flag),
        .mask (mask),
        .irq  (irq)
    );
endmodule

// File: rtl/irq_sense_ctrl_chk.sv
module irq_sense_ctrl_chk
    import isc_pkg::*;
#(
    parameter int            N     = 4,
    parameter logic [2*N-1:0] MODES = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] pin,
    input logic [N-1:0] sense,
    input logic [N-1:0] ev,
    input logic [N-1:0] flag,
    input logic [N-1:0] mask,
    input logic [1:0]   addr,
    input logic         wr,
    input logic [N-1:0] wdata,
    input logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        // R1: an accepted level is one the pin held two edges earlier
        p_sense_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[i] != $past(sense[i])) |-> (sense[i] == $past(pin[i], 2)));

        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !(wr && addr == ADDR_FLAG && wdata[i])) |=> flag[i]);

        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag[i]);

        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == ADDR_FLAG && wdata[i] && !ev[i]) |=> !flag[i]);

        if (MODES[2*i +: 2] == MODE_RISE) begin : g_r
            p_mode_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag[i]) |-> $past(sense[i]));
        end else if (MODES[2*i +: 2] == MODE_FALL) begin : g_f
            p_mode_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag[i]) |-> !$past(sense[i]));
        end
    end

    p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADDR_MASK) |=> (mask == $past(mask)));
endmodule

bind irq_sense_ctrl irq_sense_ctrl_chk #(.N(N), .MODES(MODES)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .sense(sense),
    .ev   (ev),
    .flag (flag),
    .mask (mask),
    .addr (addr),
    .wr   (wr),
    .wdata(wdata),
    .irq  (irq)
);

// File: tb/tb_irq_sense_ctrl.sv
module tb_irq_sense_ctrl;
    localparam int N = 4;
    localparam int CW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b1;
    logic [3:0]   pin = '0;
    logic [7:0]   fall_ext = '0;
    logic [1:0]   addr = '0;
    logic         wr = 1'b0;
    logic [3:0]   wdata = '0;
    logic [3:0]   rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_sense = '0, exp_flag = '0, exp_mask = '1;

    always #5 clk = ~clk;

    irq_sense_ctrl #(
        .N(N), .CW(CW),
        .RISE_TICKS({8'd5, 8'd4, 8'd6, 8'd0}),
        .FALL_TICKS({8'd5, 8'd4, 8'd3, 8'd0}),
        .MODES({2'd2, 2'd1, 2'd2, 2'd0}),
        .EXT_EN(4'b0100)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin(pin),
        .fall_ext(fall_ext), .addr(addr), .wr(wr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    function automatic int mode_of(int i);
        case (i)
            0: return 0;
            2: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int lim_of(int i, logic v);
        case (i)
            0: return 0;
            1: return v ? 6 : 3;
            2: return v ? 4 : (4 << fall_ext[5:4]);
            default: return 5;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        if (a == 2'd1) exp_flag &= ~d;
        if (a == 2'd2) exp_mask = d;
    endtask

    task automatic note_edge(int i, logic v);
        if (v != exp_sense[i]) begin
            exp_sense[i] = v;
            if (mode_of(i) == 2 || (mode_of(i) == 0 && v) || (mode_of(i) == 1 && !v))
                exp_flag[i] = 1'b1;
        end
    endtask

    task automatic check_all(string tag);
        logic [3:0] d;
        @(negedge clk);
        rd(2'd0, d); chk({tag, " sense"}, d, exp_sense);
        rd(2'd1, d); chk({tag, " flags"}, d, exp_flag);
        rd(2'd2, d); chk({tag, " mask"}, d, exp_mask);
        chk({tag, " irq R7"}, irq, |(exp_flag & ~exp_mask));
    endtask

    // change pin i to v and check the exact cycle the sense bit moves
    task automatic measure(string tag, int i, logic v);
        logic [3:0] d;
        int l;
        l = lim_of(i, v);
        @(negedge clk);
        pin[i] = v;
        repeat (2 + l) @(negedge clk);
        rd(2'd0, d); chk({tag, " before"}, d[i], !v);
        @(negedge clk);
        rd(2'd0, d); chk({tag, " after"}, d[i], v);
        note_edge(i, v);
        repeat (3) @(negedge clk);
    endtask

    task automatic hold(int i, logic v);
        @(negedge clk);
        pin[i] = v;
        repeat (45) @(negedge clk);
        note_edge(i, v);
    endtask

    task automatic glitch(int i, int w);
        @(negedge clk);
        pin[i] = !exp_sense[i];
        repeat (w) @(negedge clk);
        pin[i] = exp_sense[i];
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [3:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R9 reset");

        // R1 latency, zero count
        measure("R1 src0 rise", 0, 1'b1);
        check_all("R5 rise-only sets");
        wreg(2'd1, 4'b0001);
        measure("R5 src0 fall", 0, 1'b0);
        check_all("R5 rise-only ignores fall");

        // R6: clear in the same cycle as a new event
        @(negedge clk);
        pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        addr = 2'd1; wdata = 4'b0001; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        note_edge(0, 1'b1);
        check_all("R6 set wins");
        wreg(2'd1, 4'b0001);
        check_all("R6 w1c");
        hold(0, 1'b0);

        // R3 asymmetric counts
        measure("R3 src1 rise", 1, 1'b1);
        measure("R3 src1 fall", 1, 1'b0);
        check_all("R5 dual");

        // R4 extended falling count
        for (int c = 0; c < 4; c++) begin
            fall_ext = {2'd3, 2'(c), 2'd3, 2'd3};
            measure("R4 src2 rise", 2, 1'b1);
            measure("R4 src2 ext fall", 2, 1'b0);
        end
        measure("R4 src3 unaffected", 3, 1'b1);
        measure("R4 src3 unaffected", 3, 1'b0);
        check_all("R5 fall-only");

        // R2 glitches
        wreg(2'd1, 4'b1111);
        glitch(3, 4);
        glitch(1, 5);
        check_all("R2 glitch ignored");
        hold(3, 1'b1);
        check_all("R2 long hold");

        // R7 mask gating
        wreg(2'd2, 4'b0111);
        check_all("R7 unmasked");
        wreg(2'd2, 4'b1111);
        check_all("R7 masked");

        // R8 map
        wreg(2'd0, 4'b1111);
        check_all("R8 sense write ignored");
        @(negedge clk);
        rd(2'd3, d); chk("R8 addr3", d, 0);

        // R10 tick gating
        tick_en = 1'b0;
        @(negedge clk);
        pin[3] = 1'b0;
        repeat (20) @(negedge clk);
        rd(2'd0, d); chk("R10 held", d[3], 1);
        tick_en = 1'b1;
        repeat (10) @(negedge clk);
        note_edge(3, 1'b0);
        check_all("R10 resumed");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int i, l;
            i = int'($urandom % 4);
            if (i == 2 && ($urandom % 2) == 0) begin
                fall_ext[5:4] = 2'($urandom % 4);
                repeat (2) @(negedge clk);
            end
            l = lim_of(i, !exp_sense[i]);
            if (($urandom % 3) == 0 && l >= 3)
                glitch(i, 1 + int'($urandom % (l - 2)));
            else
                hold(i, !exp_sense[i]);
            if (($urandom % 4) == 0) wreg(2'd2, 4'($urandom));
            if (($urandom % 3) == 0) wreg(2'd1, 4'($urandom));
            check_all("R2 R3 R5 R7 random");
        end

        finish_run();
    end
endmodule